// File: doc/BRIEF.md
# SDRAM Burst Column Sequencer

This block drives the data side of a single-data-rate synchronous DRAM behavioural model. A read or write command carries a bank and a 10-bit start column. From that command the block sends one column address per valid clock to the storage array until the programmed burst is complete. Burst length and wrap order come from a separate mode register, which supplies them on plain inputs. When a command is accepted, the block latches the length and order for the life of that burst.

For reads, the array returns the addressed byte in the same cycle. The block carries that byte through a pipeline and puts it on the data output after a CAS latency of two or three valid clocks. A byte mask sampled two valid clocks earlier can hold the output in high impedance. For writes, the byte presented at an edge goes to the column issued at that edge, unless the mask is high in the same clock.

The data paths have no valid/ready pair. The DRAM protocol fixes every beat to a clock, so the array must take each write beat when it appears and the controller must take each read beat when it appears. Back-pressure is expressed only through the clock enable, which freezes the whole block for one cycle per low sample.

Top module: `sdr_burst_seq`

## Requirements
- R1: While reset is low, col_valid, col_we and dq_oe are all low.
- R2: mode_len selects the number of beats per burst: code 0 gives 1 beat, code 1 gives 2, code 2 gives 4, code 3 gives 8, and code 7 selects full page. Codes 4 to 6 behave as code 0. Beat 0 is presented, with the command's column and bank, in the cycle after the command edge. One further beat is presented per valid edge.
- R3: For 2, 4 and 8 beats with mode_interleave low, only the low log2(length) column bits change. Beat k has those bits equal to (start + k) modulo the length, and the upper bits stay those of the start column.
- R4: With mode_interleave high and 2, 4 or 8 beats, the low log2(length) bits of beat k are the start bits XOR k. Full page is always sequential.
- R5: A full-page burst presents start + k modulo 1024. After column 1023 it continues at 0 and repeats without end.
- R6: A burst_stop at a valid edge, during a full-page burst and with no command at the same edge, ends the burst, so no column is presented after that edge. In any other mode burst_stop has no effect.
- R7: For a read beat presented in cycle k, the array byte appears on dq_out with dq_oe high after valid edge k+2 (mode_cl3 low) or k+3 (mode_cl3 high). After the last beat has been driven, dq_oe returns low.
- R8: dqm high at a valid edge forces dq_oe low in the cycle that follows the second valid edge after it.
- R9: For a write beat, dqm high at the edge that carries its data keeps col_we low for that beat, so the stored byte keeps its old value. col_wdata carries the wdata sampled at the beat's edge.
- R10: With mode_single_wr high, a write command writes only its start column, whatever the length. Reads keep the programmed length.
- R11: A command at any valid edge, including the edge right after a previous command, cancels the current burst and starts the new one.
- R12: cke low at an edge makes the next edge invalid. At that edge the burst counter, the data and mask pipelines and all outputs hold, and any command or stop is ignored.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Asynchronous active-low reset |
| cke | input | 1 | Clock enable, affects the following edge |
| cmd_valid | input | 1 | Read or write command at this edge |
| cmd_write | input | 1 | 1 = write, 0 = read |
| cmd_bank | input | 2 | Bank of the command |
| cmd_col | input | 10 | Start column |
| burst_stop | input | 1 | Stop a full-page burst |
| mode_len | input | 3 | Burst length code |
| mode_interleave | input | 1 | 1 = interleaved order |
| mode_cl3 | input | 1 | 1 = CAS latency 3, 0 = latency 2 |
| mode_single_wr | input | 1 | Writes touch one column only |
| dqm | input | 1 | Byte mask |
| wdata | input | 8 | Write data |
| arr_rdata | input | 8 | Array byte at col_bank/col_addr |
| col_valid | output | 1 | A beat is presented |
| col_bank | output | 2 | Bank of the beat |
| col_addr | output | 10 | Column of the beat |
| col_we | output | 1 | Array write strobe |
| col_wdata | output | 8 | Byte to write |
| dq_out | output | 8 | Read data |
| dq_oe | output | 1 | Read data driven |

## Verification
Several rules are checked by the assertions on every cycle. The reset state is checked, and so is the fact that a command shows its column and bank in the next cycle. The assertions also check that a single-write command stops after one beat and that a stop in full-page mode removes the next column. Masking is checked for both directions: a write mask clears the strobe, and a read mask blanks the output two valid edges later. A frozen edge must leave every output unchanged. The wrap orders, the full 1024-column roll-over, the read data value and its latency, and the array contents after masked writes need the bench's reference model. That model compares every output on every clock over runs that cover each length, both orders, both latencies, back-to-back commands and clock-enable gaps.

// File: rtl/sdr_burst_pkg.sv
`timescale 1ns/1ps
package sdr_burst_pkg;
  typedef enum logic [2:0] {
    LEN_1    = 3'd0,
    LEN_2    = 3'd1,
    LEN_4    = 3'd2,
    LEN_8    = 3'd3,
    LEN_PAGE = 3'd7
  } burst_len_e;

  // log2 of beat count for fixed lengths; unknown codes act as one beat
  function automatic logic [1:0] len_log2(input logic [2:0] code);
    case (code)
      LEN_2:   return 2'd1;
      LEN_4:   return 2'd2;
      LEN_8:   return 2'd3;
      default: return 2'd0;
    endcase
  endfunction

  function automatic logic is_page(input logic [2:0] code);
    return code == LEN_PAGE;
  endfunction
endpackage

// File: rtl/sdr_burst_ctrl.sv
`timescale 1ns/1ps
module sdr_burst_ctrl
  import sdr_burst_pkg::*;
#(
  parameter int COL_W  = 10,
  parameter int BANK_W = 2,
  parameter int DATA_W = 8
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              ce,
  input  logic              cmd_valid,
  input  logic              cmd_write,
  input  logic [BANK_W-1:0] cmd_bank,
  input  logic [COL_W-1:0]  cmd_col,
  input  logic              burst_stop,
  input  logic [2:0]        mode_len,
  input  logic              mode_interleave,
  input  logic              mode_single_wr,
  input  logic              dqm,
  input  logic [DATA_W-1:0] wdata,
  output logic              active,
  output logic              is_write,
  output logic [BANK_W-1:0] bank,
  output logic [COL_W-1:0]  start_col,
  output logic [COL_W-1:0]  beat_idx,
  output logic [2:0]        len_code,
  output logic              interleave,
  output logic [DATA_W-1:0] wr_data,
  output logic              wr_mask
);
  logic             page;
  logic [COL_W-1:0] last_idx;
  logic             at_last;

  assign page     = is_page(len_code);
  assign last_idx = COL_W'((4'd1 << len_log2(len_code)) - 4'd1);
  assign at_last  = !page && (beat_idx == last_idx);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      active     <= 1'b0;
      is_write   <= 1'b0;
      bank       <= '0;
      start_col  <= '0;
      beat_idx   <= '0;
      len_code   <= LEN_1;
      interleave <= 1'b0;
      wr_data    <= '0;
      wr_mask    <= 1'b0;
    end else if (ce) begin
      wr_data <= wdata;
      wr_mask <= dqm;
      if (cmd_valid) begin
        active     <= 1'b1;
        is_write   <= cmd_write;
        bank       <= cmd_bank;
        start_col  <= cmd_col;
        beat_idx   <= '0;
        len_code   <= (cmd_write && mode_single_wr) ? LEN_1 : mode_len;
        interleave <= mode_interleave;
      end else if (active) begin
        if ((page && burst_stop) || at_last) begin
          active <= 1'b0;
        end else begin
          beat_idx <= beat_idx + 1'b1;
        end
      end
    end
  end
endmodule

// File: rtl/sdr_burst_colgen.sv
`timescale 1ns/1ps
module sdr_burst_colgen
  import sdr_burst_pkg::*;
#(
  parameter int COL_W = 10
) (
  input  logic [COL_W-1:0] start_col,
  input  logic [COL_W-1:0] beat_idx,
  input  logic [2:0]       len_code,
  input  logic             interleave,
  output logic [COL_W-1:0] col
);
  logic             page;
  logic [1:0]       span_lg;
  logic [COL_W-1:0] seq_sum;

  assign page    = is_page(len_code);
  assign span_lg = len_log2(len_code);
  assign seq_sum = start_col + beat_idx;

  for (genvar i = 0; i < COL_W; i++) begin : g_bit
    logic in_span;
    logic moved;
    assign in_span = page || (32'(span_lg) > i);
    assign moved   = (interleave && !page) ? (start_col[i] ^ beat_idx[i]) : seq_sum[i];
    assign col[i]  = in_span ? moved : start_col[i];
  end
endmodule

// File: rtl/sdr_burst_rdpipe.sv
`timescale 1ns/1ps
module sdr_burst_rdpipe #(
  parameter int DATA_W   = 8,
  parameter int MAX_CL   = 3,
  parameter int MASK_LAG = 2
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              ce,
  input  logic              rd_beat,
  input  logic [DATA_W-1:0] arr_rdata,
  input  logic              dqm,
  input  logic              cl3,
  output logic [DATA_W-1:0] dq_out,
  output logic              dq_oe
);
  localparam int MASK_N = MASK_LAG + 1;

  logic [MAX_CL-1:0]             v_q;
  logic [MAX_CL-1:0][DATA_W-1:0] d_q;
  logic [MASK_N-1:0]             m_q;
  logic [1:0]                    tap;

  assign tap = cl3 ? 2'd2 : 2'd1;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      v_q <= '0;
      d_q <= '0;
      m_q <= '0;
    end else if (ce) begin
      v_q <= {v_q[MAX_CL-2:0], rd_beat};
      d_q <= {d_q[MAX_CL-2:0], arr_rdata};
      m_q <= {m_q[MASK_N-2:0], dqm};
    end
  end

  assign dq_oe  = v_q[tap] && !m_q[MASK_LAG];
  assign dq_out = d_q[tap];
endmodule

// File: rtl/sdr_burst_seq.sv
`timescale 1ns/1ps
module sdr_burst_seq #(
  parameter int COL_W  = 10,
  parameter int BANK_W = 2,
  parameter int DATA_W = 8
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              cke,
  input  logic              cmd_valid,
  input  logic              cmd_write,
  input  logic [BANK_W-1:0] cmd_bank,
  input  logic [COL_W-1:0]  cmd_col,
  input  logic              burst_stop,
  input  logic [2:0]        mode_len,
  input  logic              mode_interleave,
  input  logic              mode_cl3,
  input  logic              mode_single_wr,
  input  logic              dqm,
  input  logic [DATA_W-1:0] wdata,
  input  logic [DATA_W-1:0] arr_rdata,
  output logic              col_valid,
  output logic [BANK_W-1:0] col_bank,
  output logic [COL_W-1:0]  col_addr,
  output logic              col_we,
  output logic [DATA_W-1:0] col_wdata,
  output logic [DATA_W-1:0] dq_out,
  output logic              dq_oe
);
  logic              cke_q;
  logic              active;
  logic              is_write;
  logic [COL_W-1:0]  start_col;
  logic [COL_W-1:0]  beat_idx;
  logic [2:0]        len_code;
  logic              interleave;
  logic              wr_mask;

  // a low sample on cke voids the following edge
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) cke_q <= 1'b1;
    else        cke_q <= cke;
  end

  sdr_burst_ctrl #(.COL_W(COL_W), .BANK_W(BANK_W), .DATA_W(DATA_W)) u_ctrl (
    .clk(clk), .rst_n(rst_n), .ce(cke_q),
    .cmd_valid(cmd_valid), .cmd_write(cmd_write), .cmd_bank(cmd_bank), .cmd_col(cmd_col),
    .burst_stop(burst_stop), .mode_len(mode_len), .mode_interleave(mode_interleave),
    .mode_single_wr(mode_single_wr), .dqm(dqm), .wdata(wdata),
    .active(active), .is_write(is_write), .bank(col_bank), .start_col(start_col),
    .beat_idx(beat_idx), .len_code(len_code), .interleave(interleave),
    .wr_data(col_wdata), .wr_mask(wr_mask)
  );

  sdr_burst_colgen #(.COL_W(COL_W)) u_colgen (
    .start_col(start_col), .beat_idx(beat_idx), .len_code(len_code),
    .interleave(interleave), .col(col_addr)
  );

  sdr_burst_rdpipe #(.DATA_W(DATA_W)) u_rdpipe (
    .clk(clk), .rst_n(rst_n), .ce(cke_q), .rd_beat(active && !is_write),
    .arr_rdata(arr_rdata), .dqm(dqm), .cl3(mode_cl3),
    .dq_out(dq_out), .dq_oe(dq_oe)
  );

  assign col_valid = active;
  assign col_we    = active && is_write && !wr_mask;
endmodule

// File: rtl/sdr_burst_seq_chk.sv
`timescale 1ns/1ps
module sdr_burst_seq_chk #(
  parameter int COL_W  = 10,
  parameter int BANK_W = 2
) (
  input logic              clk,
  input logic              rst_n,
  input logic              cke,
  input logic              cmd_valid,
  input logic              cmd_write,
  input logic [BANK_W-1:0] cmd_bank,
  input logic [COL_W-1:0]  cmd_col,
  input logic              burst_stop,
  input logic [2:0]        mode_len,
  input logic              mode_single_wr,
  input logic              dqm,
  input logic              col_valid,
  input logic [BANK_W-1:0] col_bank,
  input logic [COL_W-1:0]  col_addr,
  input logic              col_we,
  input logic              dq_oe
);
  a_r1_reset_idle: assert property (@(posedge clk)
    !rst_n |-> (!col_valid && !col_we && !dq_oe));

  a_r11_cmd_first_beat: assert property (@(posedge clk) disable iff (!rst_n)
    (cmd_valid && $past(cke)) |=>
      (col_valid && col_addr == $past(cmd_col) && col_bank == $past(cmd_bank)));

  a_r6_page_stop: assert property (@(posedge clk) disable iff (!rst_n)
    (mode_len == 3'd7 && burst_stop && !cmd_valid && $past(cke)) |=> !col_valid);

  a_r9_write_mask: assert property (@(posedge clk) disable iff (!rst_n)
    (dqm && $past(cke)) |=> !col_we);

  a_r8_read_mask: assert property (@(posedge clk) disable iff (!rst_n)
    ($past(cke) && dqm && cke ##1 cke) |=> ##1 !dq_oe);

  a_r10_single_write: assert property (@(posedge clk) disable iff (!rst_n)
    ($past(cke) && cmd_valid && cmd_write && mode_single_wr && cke ##1 !cmd_valid)
      |=> !col_valid);

  a_r12_freeze: assert property (@(posedge clk) disable iff (!rst_n)
    !cke |-> ##2 ($stable(col_valid) && $stable(col_addr) && $stable(col_we) && $stable(dq_oe)));
endmodule

bind sdr_burst_seq sdr_burst_seq_chk #(.COL_W(COL_W), .BANK_W(BANK_W)) u_chk (.*);

// File: tb/sdr_burst_seq_tb.sv
`timescale 1ns/1ps
module sdr_burst_seq_tb;
  logic       clk = 1'b0;
  logic       rst_n = 1'b1;
  logic       cke = 1'b1;
  logic       cmd_valid = 1'b0;
  logic       cmd_write = 1'b0;
  logic [1:0] cmd_bank = '0;
  logic [9:0] cmd_col = '0;
  logic       burst_stop = 1'b0;
  logic [2:0] mode_len = 3'd0;
  logic       mode_interleave = 1'b0;
  logic       mode_cl3 = 1'b0;
  logic       mode_single_wr = 1'b0;
  logic       dqm = 1'b0;
  logic [7:0] wdata = 8'h11;
  logic [7:0] arr_rdata;
  logic       col_valid, col_we, dq_oe;
  logic [1:0] col_bank;
  logic [9:0] col_addr;
  logic [7:0] col_wdata, dq_out;

  always #2 clk = ~clk;

  sdr_burst_seq u_dut (
    .clk(clk), .rst_n(rst_n), .cke(cke), .cmd_valid(cmd_valid), .cmd_write(cmd_write),
    .cmd_bank(cmd_bank), .cmd_col(cmd_col), .burst_stop(burst_stop), .mode_len(mode_len),
    .mode_interleave(mode_interleave), .mode_cl3(mode_cl3), .mode_single_wr(mode_single_wr),
    .dqm(dqm), .wdata(wdata), .arr_rdata(arr_rdata), .col_valid(col_valid),
    .col_bank(col_bank), .col_addr(col_addr), .col_we(col_we), .col_wdata(col_wdata),
    .dq_out(dq_out), .dq_oe(dq_oe)
  );

  // storage array stand-in
  logic [7:0] mem [0:3][0:1023];
  assign arr_rdata = mem[col_bank][col_addr];

  int    checks = 0;
  int    fails = 0;
  string cur_req = "R1";
  bit    started = 0;
  bit    done = 0;

  // reference model state
  bit m_act, m_wr, m_page, m_ilv, m_wmask, cke_prev;
  int m_bank, m_start, m_idx, m_len, m_wdat;
  bit rv [3];
  int rd [3];
  bit mk [3];
  bit e_valid, e_we, e_oe;
  int e_addr, e_bank, e_wdat, e_dq;
  bit s_we;
  int s_bank, s_col, s_wdat;

  function automatic int len_of(input logic [2:0] code);
    case (code)
      3'd1: return 2;
      3'd2: return 4;
      3'd3: return 8;
      3'd7: return 1024;
      default: return 1;
    endcase
  endfunction

  function automatic int exp_col(input int st, input int idx, input int len, input bit page, input bit ilv);
    int base, off;
    if (page) return (st + idx) % 1024;
    base = st - (st % len);
    off  = st % len;
    return base + (ilv ? (off ^ idx) : ((off + idx) % len));
  endfunction

  task automatic chk(input bit ok, input string what, input int act, input int exp);
    checks++;
    if (!ok) begin
      fails++;
      $display("FAIL %s %s: actual %0h expected %0h", cur_req, what, act, exp);
    end
  endtask

  always @(negedge clk) wdata <= wdata + 8'd29;

  always @(posedge clk) begin
    started <= 1'b1;
    if (!rst_n) begin
      m_act = 0; m_wr = 0; m_idx = 0; m_wmask = 0; cke_prev = 1;
      for (int k = 0; k < 3; k++) begin rv[k] = 0; rd[k] = 0; mk[k] = 0; end
      for (int b = 0; b < 4; b++)
        for (int c = 0; c < 1024; c++) mem[b][c] <= 8'(b * 71 + c * 3 + 5);
    end else begin
      if (s_we) mem[s_bank][s_col] <= 8'(s_wdat);
      if (cke_prev) begin
        rv[2] = rv[1]; rv[1] = rv[0]; rv[0] = m_act && !m_wr;
        rd[2] = rd[1]; rd[1] = rd[0];
        rd[0] = int'(mem[m_bank][exp_col(m_start, m_idx, m_len, m_page, m_ilv)]);
        mk[2] = mk[1]; mk[1] = mk[0]; mk[0] = dqm;
        m_wdat = int'(wdata); m_wmask = dqm;
        if (cmd_valid) begin
          m_act = 1; m_wr = cmd_write; m_bank = int'(cmd_bank); m_start = int'(cmd_col);
          m_idx = 0; m_len = (cmd_write && mode_single_wr) ? 1 : len_of(mode_len);
          m_page = (m_len == 1024); m_ilv = mode_interleave;
        end else if (m_act) begin
          if (m_page && burst_stop) m_act = 0;
          else if (!m_page && m_idx == m_len - 1) m_act = 0;
          else m_idx = (m_idx + 1) % 1024;
        end
      end
      cke_prev = cke;
    end
    e_valid = m_act;
    e_addr  = exp_col(m_start, m_idx, m_len, m_page, m_ilv);
    e_bank  = m_bank;
    e_we    = m_act && m_wr && !m_wmask;
    e_wdat  = m_wdat;
    e_oe    = (mode_cl3 ? rv[2] : rv[1]) && !mk[2];
    e_dq    = mode_cl3 ? rd[2] : rd[1];
  end

  always @(negedge clk) begin
    s_we = col_we; s_bank = int'(col_bank); s_col = int'(col_addr); s_wdat = int'(col_wdata);
    if (started && !done) begin
      chk(col_valid === e_valid, "col_valid", int'(col_valid), int'(e_valid));
      if (e_valid) begin
        chk(int'(col_addr) == e_addr, "col_addr", int'(col_addr), e_addr);
        chk(int'(col_bank) == e_bank, "col_bank", int'(col_bank), e_bank);
      end
      chk(col_we === e_we, "col_we", int'(col_we), int'(e_we));
      if (e_we) chk(int'(col_wdata) == e_wdat, "col_wdata", int'(col_wdata), e_wdat);
      chk(dq_oe === e_oe, "dq_oe", int'(dq_oe), int'(e_oe));
      if (e_oe) chk(int'(dq_out) == e_dq, "dq_out", int'(dq_out), e_dq);
    end
  end

  task automatic issue(input bit wr, input int bank, input int col);
    cmd_valid = 1; cmd_write = wr; cmd_bank = 2'(bank); cmd_col = 10'(col);
    @(negedge clk);
    cmd_valid = 0;
  endtask

  task automatic settle(input int n);
    repeat (n) @(negedge clk);
  endtask

  initial begin
    @(negedge clk); rst_n = 0;
    settle(3);
    cur_req = "R1";
    chk(!col_valid && !dq_oe && !col_we, "reset outputs", int'({col_valid, col_we, dq_oe}), 0);
    rst_n = 1;
    settle(2);

    cur_req = "R2";
    for (int c = 0; c < 7; c++) begin
      mode_len = (c < 4) ? 3'(c) : 3'(c);
      issue(0, 1, 37 + c);
      settle(14);
    end

    cur_req = "R3";
    mode_len = 3'd3; issue(0, 2, 13); settle(14);
    mode_len = 3'd2; issue(1, 2, 6);  settle(8);
    issue(0, 2, 4); settle(10);

    cur_req = "R4";
    mode_interleave = 1;
    mode_len = 3'd3; issue(0, 0, 5); settle(14);
    mode_len = 3'd2; issue(1, 3, 902); settle(8);
    mode_len = 3'd1; issue(0, 3, 903); settle(8);
    mode_interleave = 0;

    cur_req = "R7";
    mode_cl3 = 1;
    mode_len = 3'd3; issue(0, 1, 250); settle(14);
    mode_len = 3'd0; issue(0, 1, 251); settle(8);
    mode_cl3 = 0;

    cur_req = "R8";
    mode_len = 3'd3; issue(0, 0, 64);
    settle(1); dqm = 1; settle(1); dqm = 0; settle(2); dqm = 1; settle(2); dqm = 0;
    settle(10);

    cur_req = "R9";
    mode_len = 3'd2; issue(1, 1, 100);
    dqm = 1; settle(1); dqm = 0; settle(1); dqm = 1; settle(1); dqm = 0;
    settle(4); issue(0, 1, 100); settle(10);

    cur_req = "R10";
    mode_single_wr = 1; mode_len = 3'd3;
    issue(1, 0, 200); settle(10);
    issue(0, 0, 200); settle(14);
    mode_single_wr = 0;

    cur_req = "R11";
    issue(0, 2, 300); issue(0, 2, 410); settle(3);
    issue(1, 2, 520); issue(0, 2, 520); settle(14);

    cur_req = "R12";
    issue(0, 3, 16); settle(2);
    cke = 0; settle(2); cke = 1; settle(1);
    cke = 0; cmd_valid = 1; cmd_col = 10'd99; settle(1); cmd_valid = 0; cke = 1;
    settle(14);

    cur_req = "R6";
    mode_len = 3'd3; issue(0, 0, 40); settle(2);
    burst_stop = 1; settle(1); burst_stop = 0; settle(12);

    cur_req = "R5";
    mode_len = 3'd7; issue(0, 1, 1000);
    settle(1100);
    cur_req = "R6";
    burst_stop = 1; settle(1); burst_stop = 0; settle(10);
    cur_req = "R5";
    issue(1, 2, 1020); settle(10);
    burst_stop = 1; settle(1); burst_stop = 0; settle(10);

    done = 1;
    $display("%0d/%0d checks passed", checks - fails, checks);
    $finish;
  end

  initial begin
    #400000;
    if (!done) begin
      checks++; fails++;
      $display("FAIL watchdog: actual timeout expected completion");
      done = 1;
      $display("%0d/%0d checks passed", checks - fails, checks);
      $finish;
    end
  end
endmodule